// File: doc/BRIEF.md
# Double-Buffered DAC Input Register

This block is the bus-side register front end of a 14-bit digital-to-analog converter. A host writes to it with ordinary memory-write cycles. The bus has an active-low chip select, an active-low write strobe, two address lines and a 14-bit active-high data bus. A write cycle can fill a low staging buffer (8 bits) or a high staging buffer (6 bits). It can also copy both staging buffers into the DAC register as one update, or load the DAC register straight from the data bus. The DAC register alone feeds the converter switches. Because of this, a 14-bit word written in two halves never reaches the converter half-updated.

The block runs on a system clock. The two active-low controls are combined into one write qualifier. That qualifier is synchronized into the clock domain, and the write commits on its rising edge. While the qualifier is low, address and data are captured on every clock, so the values present at the end of the cycle are the ones used. A build-time option selects the output code format. In unipolar format the DAC register goes out unchanged. In bipolar format the most significant bit is inverted, which gives an offset-binary code for a 2's complement input.

Top module: `dac_input_regs`

## Requirements
- R1: After reset, both staging buffers and the DAC register hold zero. `code_o` then reads 0x0000 in unipolar format and 0x2000 in bipolar format.
- R2: Address 2'b00 writes `data_i[7:0]` into the low buffer. `code_o` does not change.
- R3: Address 2'b01 writes `data_i[13:8]` into the high buffer. `data_i[7:0]` is ignored and `code_o` does not change.
- R4: Address 2'b10 copies {high buffer, low buffer} into the DAC register in a single update. The data bus is ignored.
- R5: Address 2'b11 loads `data_i[13:0]` into the DAC register. Both staging buffers take the same bits, so a following transfer with no buffer write leaves `code_o` unchanged.
- R6: A write happens only on the rising edge of the combined qualifier (`cs_ni` OR `wr_ni`). Holding either input high for a whole access causes no change. Either input may be the one that ends the cycle.
- R7: The address and data used are those present in the last clock cycle in which the qualifier was low. Changes after the qualifier rises have no effect.
- R8: In unipolar format `code_o` equals the DAC register. In bipolar format, bit 13 of `code_o` is the inverse of DAC register bit 13 and bits 12:0 are equal to it.
- R9: `code_o` changes on the SYNC_STAGES-th rising clock edge after the first edge that samples the qualifier high, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Target: 00 low buffer, 01 high buffer, 10 transfer, 11 direct load |
| data_i | input | 14 | Data bus, active high, bit 13 most significant |
| code_o | output | 14 | Code to the converter switches |

## Verification
A direct load updates the DAC register and both staging buffers in the same commit. The bench provokes this by issuing a direct load and then a transfer with no buffer write in between. The output must hold the directly loaded word through the transfer, which shows that the buffers took the bits in the same cycle as the DAC register. In the opposite order, buffer writes that follow a direct load must leave the output alone until the next transfer. Every expected value is checked on the unipolar and the bipolar build side by side.

// File: rtl/dac_in_pkg.sv
package dac_in_pkg;
  typedef enum logic [1:0] {
    OP_LOAD_LO = 2'b00,
    OP_LOAD_HI = 2'b01,
    OP_XFER    = 2'b10,
    OP_DIRECT  = 2'b11
  } op_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic commit_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], strobe_ni};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign commit_o = sync_q[STAGES-1] & ~prev_q;

  AST_SINGLE_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o); // R9
endmodule

// File: rtl/dac_buffers.sv
module dac_buffers
  import dac_in_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int LO_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              commit_i,
  output logic [DATA_W-1:0] dac_o
);
  localparam int HI_W = DATA_W - LO_W;

  op_e               cap_op_q;
  logic [DATA_W-1:0] cap_data_q;
  logic [LO_W-1:0]   lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [DATA_W-1:0] dac_q;

  // track bus while qualifier is low; last value wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_op_q   <= OP_LOAD_LO;
      cap_data_q <= '0;
    end else if (capture_i) begin
      cap_op_q   <= op_e'(addr_i);
      cap_data_q <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      hi_q  <= '0;
      dac_q <= '0;
    end else if (commit_i) begin
      unique case (cap_op_q)
        OP_LOAD_LO: lo_q <= cap_data_q[LO_W-1:0];
        OP_LOAD_HI: hi_q <= cap_data_q[DATA_W-1:LO_W];
        OP_XFER:    dac_q <= {hi_q, lo_q};
        OP_DIRECT: begin
          dac_q <= cap_data_q;
          lo_q  <= cap_data_q[LO_W-1:0];
          hi_q  <= cap_data_q[DATA_W-1:LO_W];
        end
        default: ;
      endcase
    end
  end

  assign dac_o = dac_q;

  AST_LO_NO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && cap_op_q == OP_LOAD_LO |=> $stable(dac_q)); // R2
  AST_HI_NO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && cap_op_q == OP_LOAD_HI |=> $stable(dac_q)); // R3
  AST_XFER_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && cap_op_q == OP_XFER |=> dac_q == {$past(hi_q), $past(lo_q)}); // R4
  AST_DIRECT_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && cap_op_q == OP_DIRECT |=> dac_q == {hi_q, lo_q}); // R5
endmodule

// File: rtl/code_format.sv
module code_format #(
  parameter int DATA_W  = 14,
  parameter bit BIPOLAR = 1'b0
) (
  input  logic [DATA_W-1:0] dac_i,
  output logic [DATA_W-1:0] code_o
);
  generate
    if (BIPOLAR) begin : g_bipolar
      assign code_o = {~dac_i[DATA_W-1], dac_i[DATA_W-2:0]};
    end else begin : g_unipolar
      assign code_o = dac_i;
    end
  endgenerate
endmodule

// File: rtl/dac_input_regs.sv
module dac_input_regs #(
  parameter int DATA_W      = 14,
  parameter int LO_W        = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit BIPOLAR     = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] code_o
);
  logic              qual_n;
  logic              commit;
  logic [DATA_W-1:0] dac_q;

  assign qual_n = cs_ni | wr_ni;

  strobe_sync #(.STAGES(SYNC_STAGES)) i_strobe_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_ni(qual_n),
    .commit_o (commit)
  );

  dac_buffers #(.DATA_W(DATA_W), .LO_W(LO_W)) i_dac_buffers (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(~qual_n),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .commit_i (commit),
    .dac_o    (dac_q)
  );

  code_format #(.DATA_W(DATA_W), .BIPOLAR(BIPOLAR)) i_code_format (
    .dac_i (dac_q),
    .code_o(code_o)
  );

  AST_OUT_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(code_o)); // R6
  AST_MSB_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o[DATA_W-1] == (dac_q[DATA_W-1] ^ BIPOLAR)); // R8
  AST_LOW_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o[DATA_W-2:0] == dac_q[DATA_W-2:0]); // R8
endmodule

// File: tb/test_dac_input_regs.sv
module test_dac_input_regs;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1;
  logic        wr_ni = 1'b1;
  logic [1:0]  addr = 2'b00;
  logic [13:0] data = '0;
  logic [13:0] code_uni;
  logic [13:0] code_bip;

  int checks = 0;
  int errors = 0;
  logic [7:0]  m_lo = '0;
  logic [5:0]  m_hi = '0;
  logic [13:0] m_dac = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_input_regs #(.SYNC_STAGES(SYNC), .BIPOLAR(1'b0)) i_dac_input_regs (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .wr_ni(wr_ni),
    .addr_i(addr), .data_i(data), .code_o(code_uni));

  dac_input_regs #(.SYNC_STAGES(SYNC), .BIPOLAR(1'b1)) i_dac_input_regs_bip (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .wr_ni(wr_ni),
    .addr_i(addr), .data_i(data), .code_o(code_bip));

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req);
    check({req, " uni"}, code_uni, m_dac);
    check({req, " bip"}, code_bip, m_dac ^ 14'h2000);
  endtask

  // mode 0: wr ends the cycle, mode 1: cs ends it (R6)
  task automatic bus_write(input logic [1:0] a, input logic [13:0] d, input bit mode);
    @(negedge clk);
    addr = a; data = d;
    if (mode) wr_ni = 1'b0; else cs_ni = 1'b0;
    @(negedge clk);
    cs_ni = 1'b0; wr_ni = 1'b0;
    @(negedge clk);
    if (mode) cs_ni = 1'b1; else wr_ni = 1'b1;
    addr = ~a; data = ~d; // R7: bus changes after the qualifier rises
    @(negedge clk);
    cs_ni = 1'b1; wr_ni = 1'b1;
    repeat (SYNC + 2) @(negedge clk);
    unique case (a)
      2'b00: m_lo = d[7:0];
      2'b01: m_hi = d[13:8];
      2'b10: m_dac = {m_hi, m_lo};
      default: begin m_dac = d; m_lo = d[7:0]; m_hi = d[13:8]; end
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_out("R1 reset");

    // R2 low sweep, then R4 transfer with noisy bus
    for (int i = 0; i < 256; i++) begin
      bus_write(2'b00, {6'(i * 7), 8'(i)}, i[0]);
      check_out("R2 low load holds output");
      bus_write(2'b10, 14'(i * 91), i[1]);
      check_out("R4 transfer");
    end
    // R3 high sweep
    for (int j = 0; j < 64; j++) begin
      bus_write(2'b01, {6'(j), 8'(j * 37 + 5)}, j[0]);
      check_out("R3 high load holds output");
      bus_write(2'b10, 14'h3FFF, j[1]);
      check_out("R4 transfer after high");
    end
    // R5 direct load, then transfer must repeat the same word
    for (int k = 0; k < 1024; k++) begin
      bus_write(2'b11, 14'(k * 16 + (k % 16)), k[0]);
      check_out("R5 direct load");
      bus_write(2'b10, 14'(~k), k[1]);
      check_out("R5 transfer after direct");
    end
    // R5 buffers written after direct load stay hidden until transfer
    bus_write(2'b11, 14'h2A55, 1'b0);
    bus_write(2'b00, 14'h00C3, 1'b1);
    bus_write(2'b01, 14'h1500, 1'b0);
    check_out("R5 staged after direct");
    bus_write(2'b10, 14'h0000, 1'b1);
    check_out("R5 staged transfer");

    // R6 only one of the two controls asserted: no write
    @(negedge clk);
    addr = 2'b11; data = 14'h1234; cs_ni = 1'b0; wr_ni = 1'b1;
    repeat (3) @(negedge clk);
    cs_ni = 1'b1;
    repeat (SYNC + 3) @(negedge clk);
    check_out("R6 cs alone ignored");
    wr_ni = 1'b0;
    repeat (3) @(negedge clk);
    wr_ni = 1'b1;
    repeat (SYNC + 3) @(negedge clk);
    check_out("R6 wr alone ignored");

    // R9 commit latency on a direct load
    @(negedge clk);
    addr = 2'b11; data = 14'h3C0F; cs_ni = 1'b0; wr_ni = 1'b0;
    @(negedge clk);
    cs_ni = 1'b1; wr_ni = 1'b1; data = 14'h0000;
    repeat (SYNC) @(posedge clk);
    @(negedge clk);
    check_out("R9 not before latency");
    @(posedge clk);
    @(negedge clk);
    m_dac = 14'h3C0F; m_lo = 8'h0F; m_hi = 6'h3C;
    check_out("R9 at latency");

    summary();
  end
endmodule